// File: doc/BRIEF.md
# JESD204B Transmit Link Sequencer

This block is the link-layer front end of one JESD204B transmit lane. It sits between a sample source and an 8b/10b encoder and emits one octet per frame clock, along with a flag that marks the octet as a control character. It watches the receiver's active-low synchronization request and a local multiframe position counter. It moves through three phases: code-group synchronization, the initial lane alignment sequence, and user data.

The multiframe position is counted locally, with K frames per multiframe and one octet per frame. A one-cycle SYSREF pulse sets its phase. The synchronization request crosses into the frame clock domain through a chain of flops. When the request is released, the lane alignment sequence starts on the next multiframe boundary. It runs for four multiframes and carries a ramp from a free-running octet counter. Fixed control characters mark the multiframe edges, and the second multiframe carries the link configuration octets taken from an input bank. After the sequence the block passes samples through. Any new synchronization request returns it to code-group synchronization.

Top module: `jesd_tx_link_seq`

## Requirements
- R1: While `rst` is high, and on its release, the phase output is CGS (code 0) and the lane carries octet 0xBC with `ctrl_o` high, whatever the level of `sync_n_i`.
- R2: While the synchronized request is low, every octet is 0xBC with `ctrl_o` high and the phase output reads CGS (code 0).
- R3: `sync_n_i` passes through two flops. When it is driven high before a rising edge, the phase output cannot read ILA (code 1) before the third rising edge. The phase first reads ILA at the first multiframe position 0 from that edge on, with no boundary skipped.
- R4: The alignment sequence is exactly four multiframes of K octets. In each of them, position 0 carries 0x1C and position K-1 carries 0x7C, both with `ctrl_o` high.
- R5: In the second alignment multiframe, position 1 carries 0x9C with `ctrl_o` high. Positions 2 to CFG_N+1 carry configuration octet (position-2), taken from bits [8i+7:8i] of `cfg_bank_i`, with `ctrl_o` low.
- R6: Every other alignment octet equals an 8-bit counter that is zero in reset and increments on every frame clock after it, wrapping at 255, with `ctrl_o` low.
- R7: After the fourth alignment multiframe the phase output reads DATA (code 2), starting at multiframe position 0. `octet_o` equals `sample_i` and `ctrl_o` is low.
- R8: If `sync_n_i` is driven low during ILA or DATA, the lane carries 0xBC with `ctrl_o` high and the phase reads CGS no later than the second rising edge after it.
- R9: The multiframe position counts 0 to K-1 and wraps. A cycle with `sysref_i` high makes the next cycle position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_n_i | input | 1 | Receiver synchronization request, active low, asynchronous |
| sysref_i | input | 1 | One-cycle pulse that realigns the multiframe position |
| sample_i | input | 8 | User sample octet forwarded in the data phase |
| cfg_bank_i | input | CFG_N*8 | Link configuration octets, octet i in bits [8i+7:8i] |
| octet_o | output | 8 | Octet to the 8b/10b encoder |
| ctrl_o | output | 1 | High when `octet_o` is a control character |
| phase_o | output | 2 | Current phase: 0 CGS, 1 ILA, 2 DATA |

## Verification
A multiframe counter that is out of phase shows up on the first alignment octet. 0x1C then appears off the boundary that the SYSREF pulse set, and the phase changes on a cycle whose position is not zero. A sequence-state error of one count shows within one multiframe: the 0x9C marker and the configuration octets land in the wrong multiframe, or data starts one multiframe early or late. A ramp counter with the wrong start or step corrupts every unmarked alignment octet from the first one on. A slow or stuck synchronizer shows two rising edges after a request, when the lane still carries data or alignment octets.

// File: rtl/jesd_seq_pkg.sv
`timescale 1ns/1ps
package jesd_seq_pkg;
   typedef enum logic [1:0] {
      PH_CGS  = 2'd0,
      PH_ILA  = 2'd1,
      PH_DATA = 2'd2
   } phase_t;

   localparam logic [7:0] OCT_K28_5 = 8'hBC;  // code-group sync comma
   localparam logic [7:0] OCT_K28_0 = 8'h1C;  // multiframe start marker
   localparam logic [7:0] OCT_K28_4 = 8'h9C;  // configuration start marker
   localparam logic [7:0] OCT_K28_3 = 8'h7C;  // multiframe end marker

   localparam int unsigned ILA_MULTIFRAMES = 4;
endpackage

// File: rtl/jesd_sync_cdc.sv
`timescale 1ns/1ps
module jesd_sync_cdc #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_i,
   output logic sync_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("jesd_sync_cdc: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   // Reset to low: the lane stays in code-group sync until released.
   always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], async_i};
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/jesd_mf_pos.sv
`timescale 1ns/1ps
module jesd_mf_pos #(
   parameter int unsigned K  = 20,
   parameter int unsigned PW = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          sysref_i,
   output logic [PW-1:0] pos_o,
   output logic          wrap_next_o
);
   localparam logic [PW-1:0] LAST = PW'(K - 1);

   generate
      if (K < 2 || (2 ** PW) < K) begin : g_bad_k
         $error("jesd_mf_pos: K must be at least 2 and fit in PW bits");
      end
   endgenerate

   assign wrap_next_o = sysref_i || (pos_o == LAST);

   always_ff @(posedge clk) begin
      if (rst)              pos_o <= '0;
      else if (wrap_next_o) pos_o <= '0;
      else                  pos_o <= pos_o + 1'b1;
   end

   p_sysref_align_r9: assert property (@(posedge clk) disable iff (rst)
      sysref_i |=> (pos_o == '0));

   p_pos_step_r9: assert property (@(posedge clk) disable iff (rst)
      (!sysref_i && pos_o != LAST) |=> (pos_o == $past(pos_o) + 1'b1));
endmodule

// File: rtl/jesd_ila_gen.sv
`timescale 1ns/1ps
module jesd_ila_gen
   import jesd_seq_pkg::*;
#(
   parameter int unsigned K     = 20,
   parameter int unsigned CFG_N = 14,
   parameter int unsigned PW    = 5
) (
   input  logic [1:0]         mf_idx_i,
   input  logic [PW-1:0]      pos_i,
   input  logic [7:0]         ramp_i,
   input  logic [CFG_N*8-1:0] cfg_i,
   output logic [7:0]         octet_o,
   output logic               ctrl_o
);
   generate
      if (K < CFG_N + 3) begin : g_cfg_fit
         $error("jesd_ila_gen: configuration octets do not fit in one multiframe");
      end
   endgenerate

   always_comb begin
      int unsigned p;
      p       = 32'(pos_i);
      octet_o = ramp_i;
      ctrl_o  = 1'b0;
      if (p == 0) begin
         octet_o = OCT_K28_0;
         ctrl_o  = 1'b1;
      end else if (p == K - 1) begin
         octet_o = OCT_K28_3;
         ctrl_o  = 1'b1;
      end else if (mf_idx_i == 2'd1 && p == 1) begin
         octet_o = OCT_K28_4;
         ctrl_o  = 1'b1;
      end else if (mf_idx_i == 2'd1 && p >= 2 && p < CFG_N + 2) begin
         octet_o = cfg_i[(p-2)*8 +: 8];
      end
   end
endmodule

// File: rtl/jesd_tx_link_seq.sv
`timescale 1ns/1ps
module jesd_tx_link_seq
   import jesd_seq_pkg::*;
#(
   parameter int unsigned K           = 20,
   parameter int unsigned CFG_N       = 14,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               sync_n_i,
   input  logic               sysref_i,
   input  logic [7:0]         sample_i,
   input  logic [CFG_N*8-1:0] cfg_bank_i,
   output logic [7:0]         octet_o,
   output logic               ctrl_o,
   output logic [1:0]         phase_o
);
   localparam int unsigned PW = (K > 1) ? $clog2(K) : 1;
   localparam logic [1:0]  LAST_MF = 2'(ILA_MULTIFRAMES - 1);

   generate
      if (CFG_N < 1) begin : g_bad_cfg
         $error("jesd_tx_link_seq: CFG_N must be at least 1");
      end
   endgenerate

   logic          sync_s;
   logic [PW-1:0] mf_pos;
   logic          mf_wrap_next;
   logic [7:0]    ramp_q;
   phase_t        state_q;
   logic [1:0]    ila_mf_q;
   logic [7:0]    ila_octet;
   logic          ila_ctrl;

   jesd_sync_cdc #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .async_i (sync_n_i),
      .sync_o  (sync_s)
   );

   jesd_mf_pos #(.K(K), .PW(PW)) u_mf (
      .clk         (clk),
      .rst         (rst),
      .sysref_i    (sysref_i),
      .pos_o       (mf_pos),
      .wrap_next_o (mf_wrap_next)
   );

   jesd_ila_gen #(.K(K), .CFG_N(CFG_N), .PW(PW)) u_ila (
      .mf_idx_i (ila_mf_q),
      .pos_i    (mf_pos),
      .ramp_i   (ramp_q),
      .cfg_i    (cfg_bank_i),
      .octet_o  (ila_octet),
      .ctrl_o   (ila_ctrl)
   );

   // Free-running ramp that fills the unmarked alignment octets.
   always_ff @(posedge clk) begin
      if (rst) ramp_q <= '0;
      else     ramp_q <= ramp_q + 8'd1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= PH_CGS;
         ila_mf_q <= '0;
      end else begin
         unique case (state_q)
            PH_CGS: begin
               ila_mf_q <= '0;
               if (sync_s && mf_wrap_next) state_q <= PH_ILA;
            end
            PH_ILA: begin
               if (!sync_s) begin
                  state_q <= PH_CGS;
               end else if (mf_wrap_next) begin
                  if (ila_mf_q == LAST_MF) state_q <= PH_DATA;
                  else                     ila_mf_q <= ila_mf_q + 2'd1;
               end
            end
            default: begin
               if (!sync_s) state_q <= PH_CGS;
            end
         endcase
      end
   end

   // A low synchronized request overrides the phase at once.
   always_comb begin
      if (!sync_s || state_q == PH_CGS) begin
         octet_o = OCT_K28_5;
         ctrl_o  = 1'b1;
         phase_o = PH_CGS;
      end else if (state_q == PH_ILA) begin
         octet_o = ila_octet;
         ctrl_o  = ila_ctrl;
         phase_o = PH_ILA;
      end else begin
         octet_o = sample_i;
         ctrl_o  = 1'b0;
         phase_o = PH_DATA;
      end
   end

   p_ila_on_boundary_r3: assert property (@(posedge clk) disable iff (rst)
      (phase_o == PH_ILA && $past(phase_o) == PH_CGS) |-> (mf_pos == '0));

   p_data_on_boundary_r7: assert property (@(posedge clk) disable iff (rst)
      (phase_o == PH_DATA && $past(phase_o) == PH_ILA) |-> (mf_pos == '0 && $past(ila_mf_q) == LAST_MF));

   p_data_no_ctrl_r7: assert property (@(posedge clk) disable iff (rst)
      (phase_o == PH_DATA) |-> !ctrl_o);

   p_drop_to_cgs_r8: assert property (@(posedge clk) disable iff (rst)
      !sync_s |=> (state_q == PH_CGS));

   p_ila_edges_ctrl_r4: assert property (@(posedge clk) disable iff (rst)
      (state_q == PH_ILA && sync_s && mf_wrap_next) |-> (ctrl_o && octet_o == OCT_K28_3));
endmodule

// File: tb/jesd_tx_link_seq_tb_top.sv
`timescale 1ns/1ps
module jesd_tx_link_seq_tb_top;
   import jesd_seq_pkg::*;

   localparam int unsigned K     = 20;
   localparam int unsigned CFG_N = 14;
   localparam int unsigned N_SCN = 4;
   // Scenario table: negedge index of release, of the SYSREF pulse, config seed.
   localparam int         SCN_REL  [N_SCN] = '{5, 30, 50, 19};
   localparam int         SCN_SREF [N_SCN] = '{2, 11, 47, 0};
   localparam logic [7:0] SCN_SEED [N_SCN] = '{8'h11, 8'hA5, 8'h3C, 8'hF0};

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               sync_n = 1'b0;
   logic               sysref = 1'b0;
   logic [7:0]         sample = 8'h00;
   logic [CFG_N*8-1:0] cfg = '0;
   logic [7:0]         octet;
   logic               ctrl;
   logic [1:0]         phase;
   logic [10:0]        got;

   always #2 clk = ~clk;

   jesd_tx_link_seq #(.K(K), .CFG_N(CFG_N), .SYNC_STAGES(2)) dut_i (
      .clk        (clk),
      .rst        (rst),
      .sync_n_i   (sync_n),
      .sysref_i   (sysref),
      .sample_i   (sample),
      .cfg_bank_i (cfg),
      .octet_o    (octet),
      .ctrl_o     (ctrl),
      .phase_o    (phase)
   );

   assign got = {phase, ctrl, octet};

   // Requirement-level model: frame count since reset (R6) and multiframe position (R9).
   int unsigned bcyc;
   int unsigned bpos;
   always @(posedge clk) begin
      if (rst) begin
         bcyc <= 0;
         bpos <= 0;
      end else begin
         bcyc <= bcyc + 1;
         bpos <= (sysref || bpos == K - 1) ? 0 : bpos + 1;
      end
   end

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp_v);
      end
   endtask

   task automatic set_cfg(input logic [7:0] seed);
      for (int i = 0; i < CFG_N; i++) cfg[i*8 +: 8] = seed + 8'(i * 29);
   endtask

   task automatic do_reset;
      rst = 1'b1; sync_n = 1'b0; sysref = 1'b0;
      repeat (3) @(negedge clk);
      check(got == {PH_CGS, 1'b1, OCT_K28_5}, "R1 reset state", 32'(got), 32'({PH_CGS, 1'b1, OCT_K28_5}));
      rst = 1'b0;
   endtask

   // Runs code-group sync, releases the request and stops on the first ILA octet.
   task automatic launch(input int rel, input int sref);
      int since   = -1;
      bit started = 1'b0;
      bit bad_cgs = 1'b0;
      bit missed  = 1'b0;
      for (int t = 0; t < 300 && !started; t++) begin
         @(negedge clk);
         if (since >= 0) since++;
         if (phase == PH_ILA) begin
            started = 1'b1;
            check(since >= 3 && bpos == 0, "R3 R9 ILA start edge/position", 32'(since), 32'(bpos));
         end else begin
            if (got != {PH_CGS, 1'b1, OCT_K28_5}) bad_cgs = 1'b1;
            if (since >= 3 && bpos == 0) missed = 1'b1;
            sysref = (t == sref);
            if (t == rel) begin
               sync_n = 1'b1;
               since  = 0;
            end
         end
      end
      sysref = 1'b0;
      check(!bad_cgs, "R2 comma during CGS", 32'(bad_cgs), 32'd0);
      check(started && !missed, "R3 ILA on first boundary", {30'd0, started, missed}, 32'd2);
   endtask

   task automatic ila_walk(input logic [7:0] seed, input int n);
      for (int j = 0; j < n; j++) begin
         int m;
         int p;
         logic [7:0] e_oct;
         logic       e_ctl;
         string      req;
         if (j > 0) @(negedge clk);
         m = j / K;
         p = j % K;
         e_oct = bcyc[7:0];
         e_ctl = 1'b0;
         req   = "R6 ramp octet";
         if (p == 0) begin
            e_oct = 8'h1C; e_ctl = 1'b1; req = "R4 start marker";
         end else if (p == K - 1) begin
            e_oct = 8'h7C; e_ctl = 1'b1; req = "R4 end marker";
         end else if (m == 1 && p == 1) begin
            e_oct = 8'h9C; e_ctl = 1'b1; req = "R5 config marker";
         end else if (m == 1 && p >= 2 && p < CFG_N + 2) begin
            e_oct = seed + 8'((p - 2) * 29); req = "R5 config octet";
         end
         check(got == {PH_ILA, e_ctl, e_oct}, req, 32'(got), 32'({PH_ILA, e_ctl, e_oct}));
      end
   endtask

   task automatic data_walk(input int n);
      for (int d = 0; d < n; d++) begin
         @(negedge clk);
         if (d == 0) check(bpos == 0, "R7 data starts on boundary", 32'(bpos), 32'd0);
         check(got == {PH_DATA, 1'b0, sample}, "R7 data passthrough", 32'(got), 32'({PH_DATA, 1'b0, sample}));
         sample = sample * 8'd5 + 8'(d + 1);
      end
   endtask

   initial begin
      do_reset();
      for (int s = 0; s < N_SCN; s++) begin
         set_cfg(SCN_SEED[s]);
         sample = SCN_SEED[s] ^ 8'h5A;
         do_reset();
         launch(SCN_REL[s], SCN_SREF[s]);
         ila_walk(SCN_SEED[s], 4 * K);
         data_walk(6);
      end

      // Request during DATA: comma by the second edge.
      sync_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(got == {PH_CGS, 1'b1, OCT_K28_5}, "R8 drop from DATA", 32'(got), 32'({PH_CGS, 1'b1, OCT_K28_5}));

      // Relaunch, then request in the middle of the first alignment multiframe.
      launch(0, -1);
      ila_walk(SCN_SEED[N_SCN-1], 6);
      sync_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(got == {PH_CGS, 1'b1, OCT_K28_5}, "R8 drop from ILA", 32'(got), 32'({PH_CGS, 1'b1, OCT_K28_5}));

      // Reset in DATA with the request released still forces CGS.
      launch(0, -1);
      ila_walk(SCN_SEED[N_SCN-1], 4 * K);
      data_walk(2);
      rst = 1'b1;
      @(negedge clk);
      check(got == {PH_CGS, 1'b1, OCT_K28_5}, "R1 reset with sync high", 32'(got), 32'({PH_CGS, 1'b1, OCT_K28_5}));
      rst = 1'b0;
      @(negedge clk);
      check(got == {PH_CGS, 1'b1, OCT_K28_5}, "R1 after reset release", 32'(got), 32'({PH_CGS, 1'b1, OCT_K28_5}));

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog (all): actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule